// File: doc/BRIEF.md
# Three-Speed I2C Clock Phase Generator

This block produces the serial clock waveform for an I2C bus master. Three pairs of programmable counts are kept, one pair for each bus speed (standard, fast and high-speed). A two-bit speed field in a small control register picks the active pair. While the controller is enabled, a down-counter measures out a low phase of the selected low count, then a high phase of the selected high count, and repeats.

At every edge of the generated clock, a one-cycle tick goes to the bit engine of the master, so that the engine can shift or sample data without decoding the waveform itself. Configuration writes are accepted only while the controller is disabled. A count that is too small to form a sensible phase is raised to a floor value.

Top module: `scl_timer`

## Requirements
- R1: Reset state. After reset `scl_o` is high and both ticks are low. The speed field holds 1 (standard). The count pairs (high/low) hold 0x75/0x7C for standard, 0x15/0x21 for fast and 0x07/0x0E for high-speed, so the first enabled run gives 124 low cycles and 117 high cycles.
- R2: While `ctl_enable` is low, `scl_o` stays high and neither tick is raised, from the clock edge after `ctl_enable` is sampled low.
- R3: When `ctl_enable` is sampled high with the clock idle, `scl_o` goes low at that edge. It stays low for exactly the effective low count in cycles, then high for exactly the effective high count in cycles, and the pattern repeats.
- R4: The speed field is bits 2:1 of the control register at address 0x00. Value 1 selects the standard pair, 2 the fast pair and 3 the high-speed pair. Value 0 behaves as standard.
- R5: Each count register is 16 bits. Standard high/low are at 0x14/0x18, fast high/low at 0x1C/0x20, and high-speed high/low at 0x24/0x28. A write to one pair leaves the other pairs unchanged.
- R6: A programmed count below 6 is used as 6. Values of 6 and above are used unchanged.
- R7: A write, to the control register or to any count register, made while `ctl_enable` is high has no effect, both during that run and in later runs.
- R8: `scl_fall_o` is high for exactly the first cycle of each low phase, and `scl_rise_o` for exactly the first cycle of each high phase. Both are never high together.
- R9: Dropping `ctl_enable` mid-phase returns `scl_o` high at the next edge with no tick. The next enable starts a full-length low phase.
- R10: A write to an address other than the seven listed above changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Controller enable; high runs the clock, low idles it and opens configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 16 | Configuration write data |
| scl_o | output | 1 | Generated serial clock level |
| scl_rise_o | output | 1 | One-cycle tick in the first cycle of a high phase |
| scl_fall_o | output | 1 | One-cycle tick in the first cycle of a low phase |

## Verification
The phase counter is run with the reset default pair and with each speed value in turn, including 0. Each speed is given distinct low and high lengths, so a swapped pair or a wrong decode shows up as a length mismatch. Counts of 0, 3, 6 and 7 separate the floor from a plain pass-through and find an off-by-one at the limit. Writes made during a run, writes to unused or misaligned addresses, and an enable dropped part-way through a phase are each followed by a fresh run, which shows whether any hidden state was disturbed.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;

  localparam int unsigned NUM_SPEEDS = 3;

  typedef enum logic [1:0] {
    PAIR_STD  = 2'd0,
    PAIR_FAST = 2'd1,
    PAIR_HS   = 2'd2
  } pair_e;

  // Map the two-bit speed field onto a count-pair index; zero falls back to standard.
  function automatic pair_e pair_from_field(input logic [1:0] fld);
    case (fld)
      2'd2:    return PAIR_FAST;
      2'd3:    return PAIR_HS;
      default: return PAIR_STD;
    endcase
  endfunction

  // Raise a programmed count to the floor value when it is too small.
  function automatic int unsigned floor_count(input int unsigned raw, input int unsigned lim);
    return (raw < lim) ? lim : raw;
  endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_timer_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CNT_W       = 16,
  parameter int CTRL_OFS    = 'h00,
  parameter int SPD_LSB     = 1,
  parameter int PAIR_BASE   = 'h14,
  parameter int PAIR_STRIDE = 8,
  parameter int LOW_DELTA   = 4,
  parameter logic [1:0] SPEED_RST = 2'd1,
  parameter logic [CNT_W-1:0] HIGH_RST [NUM_SPEEDS] = '{'h75, 'h15, 'h07},
  parameter logic [CNT_W-1:0] LOW_RST  [NUM_SPEEDS] = '{'h7C, 'h21, 'h0E}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  high_raw,
  output logic [CNT_W-1:0]  low_raw
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

  logic [1:0]       speed_q;
  pair_e            sel_pair;
  logic [CNT_W-1:0] hi_arr [NUM_SPEEDS];
  logic [CNT_W-1:0] lo_arr [NUM_SPEEDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q <= SPEED_RST;
    end else if (wr_ok && addr == CTRL_A) begin
      speed_q <= wdata[SPD_LSB +: 2];
    end
  end

  for (genvar m = 0; m < NUM_SPEEDS; m++) begin : g_pair
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(PAIR_BASE + m * PAIR_STRIDE);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(PAIR_BASE + m * PAIR_STRIDE + LOW_DELTA);
    logic [CNT_W-1:0] hi_q;
    logic [CNT_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= HIGH_RST[m];
        lo_q <= LOW_RST[m];
      end else begin
        if (wr_ok && addr == HI_A) hi_q <= wdata;
        if (wr_ok && addr == LO_A) lo_q <= wdata;
      end
    end

    assign hi_arr[m] = hi_q;
    assign lo_arr[m] = lo_q;
  end

  assign sel_pair = pair_from_field(speed_q);
  assign high_raw = hi_arr[sel_pair];
  assign low_raw  = lo_arr[sel_pair];

endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] high_len,
  input  logic [CNT_W-1:0] low_len,
  output logic             scl,
  output logic             rise_tick,
  output logic             fall_tick
);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_done;

  assign phase_done = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl       <= 1'b1;
      cnt_q     <= '0;
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
    end else if (!run) begin
      scl       <= 1'b1;
      cnt_q     <= '0;
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
    end else begin
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
      if (!phase_done) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (scl) begin
        scl       <= 1'b0;
        cnt_q     <= low_len - 1'b1;
        fall_tick <= 1'b1;
      end else begin
        scl       <= 1'b1;
        cnt_q     <= high_len - 1'b1;
        rise_tick <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/scl_timer.sv
module scl_timer
  import scl_timer_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  output logic              scl_o,
  output logic              scl_rise_o,
  output logic              scl_fall_o
);

  logic             cfg_wr_ok;
  logic [CNT_W-1:0] high_raw;
  logic [CNT_W-1:0] low_raw;
  logic [CNT_W-1:0] high_eff;
  logic [CNT_W-1:0] low_eff;

  // Configuration is frozen while the controller runs.
  assign cfg_wr_ok = cfg_we && !ctl_enable;

  always_comb begin
    high_eff = CNT_W'(floor_count(32'(high_raw), MIN_CNT));
    low_eff  = CNT_W'(floor_count(32'(low_raw), MIN_CNT));
  end

  scl_cfg_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (cfg_wr_ok),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .high_raw (high_raw),
    .low_raw  (low_raw)
  );

  scl_phase_cnt #(
    .CNT_W (CNT_W)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctl_enable),
    .high_len  (high_eff),
    .low_len   (low_eff),
    .scl       (scl_o),
    .rise_tick (scl_rise_o),
    .fall_tick (scl_fall_o)
  );

endmodule

// File: rtl/scl_timer_chk.sv
module scl_timer_chk #(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_enable,
  input logic             scl,
  input logic             rise,
  input logic             fall,
  input logic [CNT_W-1:0] high_eff,
  input logic [CNT_W-1:0] low_eff
);

  logic [CNT_W:0] run_cnt;
  logic           seen_rise;

  // Cycles since the last tick; at a tick it equals the length of the phase just ended.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= '0;
      seen_rise <= 1'b0;
    end else begin
      run_cnt <= (rise || fall) ? (CNT_W+1)'(1) : run_cnt + 1'b1;
      if (!ctl_enable) seen_rise <= 1'b0;
      else if (rise)   seen_rise <= 1'b1;
    end
  end

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> (scl && !rise && !fall));

  a_r3_low_len: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> run_cnt == {1'b0, low_eff});

  a_r3_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && seen_rise) |-> run_cnt == {1'b0, high_eff});

  a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> run_cnt >= (CNT_W+1)'(MIN_CNT));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_enable && $past(ctl_enable)) |-> ($stable(high_eff) && $stable(low_eff)));

  a_r8_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl) |-> fall);

  a_r8_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl) && $past(ctl_enable)) |-> rise);

  a_r8_tick_level: assert property (@(posedge clk) disable iff (!rst_n)
    (rise |-> scl) and (fall |-> !scl));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));

endmodule

bind scl_timer scl_timer_chk #(
  .CNT_W   (CNT_W),
  .MIN_CNT (MIN_CNT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_enable (ctl_enable),
  .scl        (scl_o),
  .rise       (scl_rise_o),
  .fall       (scl_fall_o),
  .high_eff   (high_eff),
  .low_eff    (low_eff)
);

// File: tb/scl_timer_tb.sv
module scl_timer_tb;

  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        scl_o;
  logic        scl_rise_o;
  logic        scl_fall_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  typedef struct {
    bit    lvl;
    int    len;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  always #2 clk = ~clk;

  scl_timer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_enable (ctl_enable),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .scl_o      (scl_o),
    .scl_rise_o (scl_rise_o),
    .scl_fall_o (scl_fall_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic push_phases(input string tag, input int lo, input int hi);
    for (int p = 0; p < 2; p++) begin
      sb_q.push_back('{lvl: 1'b0, len: lo, tag: tag});
      sb_q.push_back('{lvl: 1'b1, len: hi, tag: tag});
    end
  endtask

  task automatic wait_drain(input string tag);
    int t = 0;
    while (sb_q.size() != 0 && t < 20000) begin
      @(posedge clk); t++;
    end
    check({tag, " scoreboard drained"}, sb_q.size(), 0);
    sb_q.delete();
  endtask

  task automatic stop_run();
    @(posedge clk); #1;
    ctl_enable = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic run(input string tag, input int lo, input int hi);
    push_phases(tag, lo, hi);
    @(posedge clk); #1;
    ctl_enable = 1'b1;
    wait_drain(tag);
    stop_run();
  endtask

  task automatic idle_check(input string tag, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      check({tag, " idle scl"}, int'(scl_o), 1);
      check({tag, " idle ticks"}, int'(scl_rise_o) + int'(scl_fall_o), 0);
    end
  endtask

  // Monitor: measures each completed phase and compares it with the scoreboard.
  bit ph_valid = 1'b0;
  int ph_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ctl_enable) begin
        ph_valid = 1'b0;
      end else if (scl_rise_o || scl_fall_o) begin
        check("R8 tick matches level", int'(scl_o), scl_rise_o ? 1 : 0);
        if (ph_valid && sb_q.size() != 0) begin
          exp_t e;
          e = sb_q.pop_front();
          check({e.tag, " phase level"}, scl_fall_o ? 1 : 0, int'(e.lvl));
          check({e.tag, " phase length"}, ph_len, e.len);
        end
        ph_valid = 1'b1;
        ph_len = 1;
      end else if (ph_valid) begin
        ph_len++;
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL R3 watchdog expired actual=%0d expected=0", WD_CYCLES);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset scl", int'(scl_o), 1);
    check("R1 reset ticks", int'(scl_rise_o) + int'(scl_fall_o), 0);
    #1 rst_n = 1'b1;
    // R2: idle while disabled
    idle_check("R2", 8);
    // R1 and R3: default standard pair
    run("R1 R3 default standard", 124, 117);
    // R4: fast and high-speed selections (field in bits 2:1 of 0x00)
    wr(8'h00, 16'h0004);
    run("R4 fast", 33, 21);
    wr(8'h00, 16'h0006);
    run("R4 high-speed", 14, 7);
    // R5: standard pair at 0x14/0x18; R4: field 0 acts as standard
    wr(8'h14, 16'd10);
    wr(8'h18, 16'd12);
    wr(8'h00, 16'h0000);
    run("R4 R5 zero field standard", 12, 10);
    wr(8'h00, 16'h0002);
    run("R4 R5 field one standard", 12, 10);
    wr(8'h00, 16'h0004);
    run("R5 fast pair untouched", 33, 21);
    // R6: floor of 6
    wr(8'h24, 16'd3);
    wr(8'h28, 16'd0);
    wr(8'h00, 16'h0006);
    run("R6 clamp below floor", 6, 6);
    wr(8'h1C, 16'd6);
    wr(8'h20, 16'd7);
    wr(8'h00, 16'h0004);
    run("R6 at floor", 7, 6);
    // R7: writes during a run are dropped
    push_phases("R7 writes while enabled", 7, 6);
    @(posedge clk); #1;
    ctl_enable = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    cfg_we = 1'b1; cfg_addr = 8'h20; cfg_wdata = 16'd40;
    @(posedge clk); #1;
    cfg_addr = 8'h00; cfg_wdata = 16'h0006;
    @(posedge clk); #1;
    cfg_addr = 8'h1C; cfg_wdata = 16'd50;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    wait_drain("R7 writes while enabled");
    stop_run();
    run("R7 later run unchanged", 7, 6);
    // R10: unused and misaligned addresses
    wr(8'h10, 16'd99);
    wr(8'h2C, 16'h0002);
    wr(8'h22, 16'd2);
    wr(8'h04, 16'h0006);
    run("R10 stray writes", 7, 6);
    // R9: abort mid-phase, then a fresh run
    @(posedge clk); #1;
    ctl_enable = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    ctl_enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9 scl high after abort", int'(scl_o), 1);
    check("R9 no tick after abort", int'(scl_rise_o) + int'(scl_fall_o), 0);
    idle_check("R9 R2", 4);
    run("R9 fresh run", 7, 6);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule